// File: doc/BRIEF.md
# Dual-Window Pixel Address Translator

This block sits between a CPU bus and a frame buffer and turns each 32-bit CPU address into a 21-bit video RAM address. It decodes two windows. In the coordinate window, the low halfword of the CPU address holds the pixel column and the bits above it hold the pixel row. Software can therefore plot a point by placing X and Y in separate halves of a pointer, with no multiply. In the linear window, the same memory appears as a flat alias, and the low address bits pass through unchanged.

A static parameter chooses how coordinates are packed into the RAM. Power-of-two packing gives every row a stride of 1024 words and leaves gaps. Contiguous packing gives a stride of 640, so the frame is dense. Address, write enable, window hits and an out-of-range flag are registered together. The RAM therefore sees a consistent request one clock after the CPU presents it.

Top module: `pix_addr_xlate`

## Requirements
- R1: A request with `addr_i[31:28]` equal to 4'h8 is a coordinate access. X is `addr_i[15:0]` and Y is `addr_i[27:16]`. `coord_hit_o` rises for it, and the two hit outputs are never high together.
- R2: A request with `addr_i[31:21]` equal to 11'h480 (0x9000_0000 to 0x901F_FFFF) is a linear access. `lin_hit_o` rises and `ram_addr_o` equals `addr_i[20:0]`.
- R3: With `POW2_PACK`=1, a coordinate access gives `ram_addr_o` = {2'b00, Y[8:0], X[9:0]}. For example, 0x81DF_027F maps to 0x77E7F.
- R4: With `POW2_PACK`=0, a coordinate access gives `ram_addr_o` = Y*640 + X, formed from two shifts and adds with no multiplier. (639,0) maps to 0x27F, (0,1) to 0x280 and (639,479) to 0x4AFFF.
- R5: A request outside both windows raises neither hit output and never `ram_we_o`.
- R6: A coordinate access with X ≥ 640 or Y ≥ 480 raises `oob_o` together with `coord_hit_o` and suppresses `ram_we_o`.
- R7: All outputs are registered and reflect the request of the previous clock. A cycle with `req_i` low yields zero hits, zero `oob_o` and no write.
- R8: During and right after reset, all outputs are zero.
- R9: A read request (`we_i`=0) inside a window raises its hit output but not `ram_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | CPU bus cycle valid |
| we_i | input | 1 | CPU write (1) or read (0) |
| addr_i | input | 32 | CPU byte/word address |
| ram_addr_o | output | 21 | Registered video RAM address |
| ram_we_o | output | 1 | Registered RAM write enable |
| coord_hit_o | output | 1 | Registered coordinate-window hit |
| lin_hit_o | output | 1 | Registered linear-window hit |
| oob_o | output | 1 | Registered out-of-range coordinate flag |

## Verification
Two functions can coincide in one cycle: the coordinate-window hit and the out-of-range flag. Both rise on the same edge, while the write must stay low. The bench provokes this by writing at X=640 and at Y=480, just past the screen edge. It then judges `coord_hit_o`, `oob_o` and `ram_we_o` together on the cycle after the request. The two packing variants run side by side on the same stimulus, and each is compared with its own closed-form address. Back-to-back requests that alternate between the windows confirm that every output follows its own request one clock later.

// File: rtl/pix_xlate_pkg.sv
package pix_xlate_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned RAM_AW   = 21;
  localparam int unsigned COORD_XW = 16;
  localparam int unsigned COORD_YW = ADDR_W - 4 - COORD_XW;  // 12
  localparam logic [3:0]  COORD_TAG = 4'h8;
  localparam int unsigned LIN_TAG_W = ADDR_W - RAM_AW;       // 11
  localparam logic [LIN_TAG_W-1:0] LIN_TAG = 11'h480;
  // 640 = 512 + 128
  localparam int unsigned STRIDE_SH_HI = 9;
  localparam int unsigned STRIDE_SH_LO = 7;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_COORD = 2'd1,
    WIN_LIN   = 2'd2
  } win_e;
endpackage

// File: rtl/pix_win_decode.sv
module pix_win_decode
  import pix_xlate_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr_i,
  output win_e                win_o,
  output logic [COORD_XW-1:0] x_o,
  output logic [COORD_YW-1:0] y_o
);
  always_comb begin
    if (addr_i[ADDR_W-1 -: 4] == COORD_TAG)
      win_o = WIN_COORD;
    else if (addr_i[ADDR_W-1 -: LIN_TAG_W] == LIN_TAG)
      win_o = WIN_LIN;
    else
      win_o = WIN_NONE;
  end

  assign x_o = addr_i[COORD_XW-1:0];
  assign y_o = addr_i[COORD_XW +: COORD_YW];
endmodule

// File: rtl/pix_coord_pack.sv
module pix_coord_pack
  import pix_xlate_pkg::*;
#(
  parameter bit          POW2_PACK = 1'b0,
  parameter int unsigned SCR_W     = 640,
  parameter int unsigned SCR_H     = 480
) (
  input  logic [COORD_XW-1:0] x_i,
  input  logic [COORD_YW-1:0] y_i,
  output logic [RAM_AW-1:0]   ram_addr_o,
  output logic                oob_o
);
  localparam int unsigned XB  = $clog2(SCR_W);
  localparam int unsigned YB  = $clog2(SCR_H);
  localparam int unsigned PAD = RAM_AW - XB - YB;

  assign oob_o = (x_i >= COORD_XW'(SCR_W)) || (y_i >= COORD_YW'(SCR_H));

  generate
    if (POW2_PACK) begin : g_pow2
      // upper bits act as bank select, held at zero
      assign ram_addr_o = {{PAD{1'b0}}, y_i[YB-1:0], x_i[XB-1:0]};
    end else begin : g_dense
      logic [RAM_AW-1:0] y_ext, x_ext;
      assign y_ext = RAM_AW'(y_i);
      assign x_ext = RAM_AW'(x_i);
      assign ram_addr_o = (y_ext << STRIDE_SH_HI) + (y_ext << STRIDE_SH_LO) + x_ext;
    end
  endgenerate
endmodule

// File: rtl/pix_out_reg.sv
module pix_out_reg
  import pix_xlate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  win_e              win_i,
  input  logic              oob_i,
  input  logic [RAM_AW-1:0] coord_addr_i,
  input  logic [RAM_AW-1:0] lin_addr_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic              coord_hit_o,
  output logic              lin_hit_o,
  output logic              oob_o
);
  logic is_coord, is_lin, wr_ok;
  logic [RAM_AW-1:0] addr_d;

  assign is_coord = req_i && (win_i == WIN_COORD);
  assign is_lin   = req_i && (win_i == WIN_LIN);
  assign wr_ok    = we_i && (is_lin || (is_coord && !oob_i));

  always_comb begin
    addr_d = '0;
    if (is_coord)    addr_d = coord_addr_i;
    else if (is_lin) addr_d = lin_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_addr_o  <= '0;
      ram_we_o    <= 1'b0;
      coord_hit_o <= 1'b0;
      lin_hit_o   <= 1'b0;
      oob_o       <= 1'b0;
    end else begin
      ram_addr_o  <= addr_d;
      ram_we_o    <= wr_ok;
      coord_hit_o <= is_coord;
      lin_hit_o   <= is_lin;
      oob_o       <= is_coord && oob_i;
    end
  end
endmodule

// File: rtl/pix_addr_xlate.sv
module pix_addr_xlate
  import pix_xlate_pkg::*;
#(
  parameter bit          POW2_PACK = 1'b0,
  parameter int unsigned SCR_W     = 640,
  parameter int unsigned SCR_H     = 480
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [31:0] addr_i,
  output logic [20:0] ram_addr_o,
  output logic        ram_we_o,
  output logic        coord_hit_o,
  output logic        lin_hit_o,
  output logic        oob_o
);
  win_e                win;
  logic [COORD_XW-1:0] px;
  logic [COORD_YW-1:0] py;
  logic [RAM_AW-1:0]   coord_addr;
  logic                oob;

  pix_win_decode u_dec (
    .addr_i (addr_i),
    .win_o  (win),
    .x_o    (px),
    .y_o    (py)
  );

  pix_coord_pack #(
    .POW2_PACK (POW2_PACK),
    .SCR_W     (SCR_W),
    .SCR_H     (SCR_H)
  ) u_pack (
    .x_i        (px),
    .y_i        (py),
    .ram_addr_o (coord_addr),
    .oob_o      (oob)
  );

  pix_out_reg u_oreg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .we_i         (we_i),
    .win_i        (win),
    .oob_i        (oob),
    .coord_addr_i (coord_addr),
    .lin_addr_i   (addr_i[RAM_AW-1:0]),
    .ram_addr_o   (ram_addr_o),
    .ram_we_o     (ram_we_o),
    .coord_hit_o  (coord_hit_o),
    .lin_hit_o    (lin_hit_o),
    .oob_o        (oob_o)
  );
endmodule

// File: rtl/pix_addr_xlate_chk.sv
module pix_addr_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [31:0] addr_i,
  input logic [20:0] ram_addr_o,
  input logic        ram_we_o,
  input logic        coord_hit_o,
  input logic        lin_hit_o,
  input logic        oob_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  logic in_coord, in_lin;
  assign in_coord = addr_i[31:28] == 4'h8;
  assign in_lin   = addr_i[31:21] == 11'h480;

  p_one_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(coord_hit_o && lin_hit_o));

  p_lin_map_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(req_i && in_lin)) |-> (lin_hit_o && ram_addr_o == $past(addr_i[20:0])));

  p_outside_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(req_i && !in_coord && !in_lin)) |-> (!coord_hit_o && !lin_hit_o && !ram_we_o));

  p_oob_nowr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oob_o |-> (!ram_we_o && coord_hit_o));

  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(req_i)) |-> (!ram_we_o && !coord_hit_o && !lin_hit_o && !oob_o));

  p_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(req_i && !we_i)) |-> !ram_we_o);
endmodule

bind pix_addr_xlate pix_addr_xlate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .ram_addr_o  (ram_addr_o),
  .ram_we_o    (ram_we_o),
  .coord_hit_o (coord_hit_o),
  .lin_hit_o   (lin_hit_o),
  .oob_o       (oob_o)
);

// File: tb/pix_addr_xlate_tb.sv
`timescale 1ns/1ps
module pix_addr_xlate_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0;

  logic [20:0] a_d, a_p;
  logic we_d, we_p, ch_d, ch_p, lh_d, lh_p, ob_d, ob_p;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pix_addr_xlate #(.POW2_PACK(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .ram_addr_o(a_d), .ram_we_o(we_d), .coord_hit_o(ch_d), .lin_hit_o(lh_d), .oob_o(ob_d));

  pix_addr_xlate #(.POW2_PACK(1'b1)) u_dut_pow2 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .ram_addr_o(a_p), .ram_we_o(we_p), .coord_hit_o(ch_p), .lin_hit_o(lh_p), .oob_o(ob_p));

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // both instances: dense addr, pow2 addr, coord hit, lin hit, oob, write
  task automatic chk_all(string tag, logic [20:0] ed, logic [20:0] ep,
                         logic ch, logic lh, logic ob, logic w);
    cmp({tag, " dense addr"}, 32'(a_d), 32'(ed));
    cmp({tag, " pow2 addr"},  32'(a_p), 32'(ep));
    cmp({tag, " coord_hit"},  32'({ch_d, ch_p}), 32'({ch, ch}));
    cmp({tag, " lin_hit"},    32'({lh_d, lh_p}), 32'({lh, lh}));
    cmp({tag, " oob"},        32'({ob_d, ob_p}), 32'({ob, ob}));
    cmp({tag, " we"},         32'({we_d, we_p}), 32'({w, w}));
  endtask

  task automatic issue(logic [31:0] a, logic w);
    @(negedge clk);
    req = 1'b1; addr = a; we = w;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  function automatic logic [31:0] xy(int x, int y);
    return {4'h8, 12'(y), 16'(x)};
  endfunction

  task automatic t_reset;
    chk_all("R8 reset", 21'h0, 21'h0, 0, 0, 0, 0);
  endtask

  task automatic t_coord;
    issue(xy(639, 0), 1);   chk_all("R1 R3 R4 (639,0)", 21'h27F, 21'h27F, 1, 0, 0, 1);
    issue(xy(0, 1), 1);     chk_all("R3 R4 (0,1)", 21'h280, 21'h400, 1, 0, 0, 1);
    issue(xy(639, 479), 1); chk_all("R3 R4 (639,479)", 21'h4AFFF, 21'h77E7F, 1, 0, 0, 1);
    issue(xy(20, 20), 1);   chk_all("R3 R4 (20,20)", 21'(12820), 21'(20500), 1, 0, 0, 1);
    issue(xy(0, 0), 1);     chk_all("R1 (0,0)", 21'h0, 21'h0, 1, 0, 0, 1);
  endtask

  task automatic t_linear;
    issue(32'h9012_3456, 1); chk_all("R2 lin mid", 21'h123456, 21'h123456, 0, 1, 0, 1);
    issue(32'h901F_FFFF, 1); chk_all("R2 lin top", 21'h1FFFFF, 21'h1FFFFF, 0, 1, 0, 1);
    issue(32'h9000_0000, 1); chk_all("R2 lin base", 21'h0, 21'h0, 0, 1, 0, 1);
  endtask

  task automatic t_outside;
    issue(32'h9020_0000, 1); chk_all("R5 past lin", 21'h0, 21'h0, 0, 0, 0, 0);
    issue(32'h7FFF_FFFF, 1); chk_all("R5 below", 21'h0, 21'h0, 0, 0, 0, 0);
    issue(32'hA000_0000, 1); chk_all("R5 above", 21'h0, 21'h0, 0, 0, 0, 0);
  endtask

  task automatic t_oob;
    issue(xy(640, 0), 1);
    cmp("R6 x=640 hit", 32'({ch_d, ch_p}), 32'b11);
    cmp("R6 x=640 oob", 32'({ob_d, ob_p}), 32'b11);
    cmp("R6 x=640 we",  32'({we_d, we_p}), 32'b00);
    issue(xy(0, 480), 1);
    cmp("R6 y=480 oob", 32'({ob_d, ob_p}), 32'b11);
    cmp("R6 y=480 we",  32'({we_d, we_p}), 32'b00);
  endtask

  task automatic t_read;
    issue(xy(5, 2), 0);       chk_all("R9 coord read", 21'(1285), 21'(2053), 1, 0, 0, 0);
    issue(32'h9000_0010, 0);  chk_all("R9 lin read", 21'h10, 21'h10, 0, 1, 0, 0);
  endtask

  task automatic t_pipe;
    @(negedge clk); req = 1'b1; we = 1'b1; addr = xy(1, 1);
    @(negedge clk); addr = 32'h9000_0ABC;
    chk_all("R7 b2b first", 21'(641), 21'(1025), 1, 0, 0, 1);
    @(negedge clk); req = 1'b0; we = 1'b0;
    chk_all("R7 b2b second", 21'hABC, 21'hABC, 0, 1, 0, 1);
    @(negedge clk);
    chk_all("R7 idle", 21'h0, 21'h0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_coord();
    t_linear();
    t_outside();
    t_oob();
    t_read();
    t_pipe();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule